// File: doc/BRIEF.md
# UART Receiver Status and Error Flags

This block is the register-side flag logic of a UART receiver. It sits between the receive shifter and the CPU bus. From the shifter it takes three things: a one-cycle strobe for each completed frame, the received byte, and two per-frame quality indications. These are a noise indication and the sampled stop-bit level. The block holds the receive data register and four sticky flags: receive-full, overrun, noise and framing error. It presents the flags as a fixed-layout status byte.

Software clears flags with a two-step sequence. First it reads the status register, then it reads the data register. On every status read, the block records which flags the bus saw as set. It records one arm bit per flag. A later data read clears only the armed flags and then drops every arm bit. A flag that becomes set between the two reads therefore survives the data read. It is still reported on the next status read, so software cannot miss it.

Three interrupt request outputs follow the overrun, noise and framing flags. Each is gated by its own enable input.

Top module: `uart_rx_status`

## Requirements
- R1: When a frame completes while receive-full is set and is not being cleared in that cycle, the overrun flag sets, the new byte is discarded, and the data register keeps the earlier byte.
- R2: A completed frame that is accepted is loaded into the data register and sets receive-full. The data appears on `rx_data` one cycle after the strobe.
- R3: A data read clears a flag only if the most recent status read returned that flag as 1. A flag that was 0 at the status read, including an overrun that sets after it, stays set through the data read.
- R4: The noise flag sets when a frame completes with `noise_in` = 1.
- R5: The framing-error flag sets when a frame completes with `stop_bit_in` = 0.
- R6: `irq_overrun`, `irq_noise` and `irq_frame` equal their flag ANDed with the matching enable input. They change in the same cycle as the flag.
- R7: Reset clears all four flags, all arm bits, the data register and the interrupt outputs.
- R8: `status` places receive-full at bit 5, overrun at bit 3, noise at bit 2 and framing error at bit 1. All other bits read 0.
- R9: A data read drops all arm bits. A second data read without a new status read clears nothing.
- R10: If a flag's set event and its armed clear occur in the same cycle, the flag ends set.
- R11: A frame completing in the same cycle as a data read that clears an armed receive-full is accepted. It loads the data register, does not set overrun, and leaves receive-full set.
- R12: When status and data reads occur in the same cycle, the data read uses the arms from the earlier status read. The arms are then reloaded from the flags returned by the concurrent status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_done | input | 1 | One-cycle strobe from the shifter: a frame has completed |
| frame_byte | input | DW | Byte received with the strobe |
| noise_in | input | 1 | Noise was seen during the completed frame |
| stop_bit_in | input | 1 | Sampled level of the stop bit |
| rd_status | input | 1 | Bus read strobe for the status register |
| rd_data | input | 1 | Bus read strobe for the data register |
| en_overrun | input | 1 | Overrun interrupt enable |
| en_noise | input | 1 | Noise interrupt enable |
| en_frame | input | 1 | Framing-error interrupt enable |
| status | output | 8 | Status register value |
| rx_data | output | DW | Receive data register |
| irq_overrun | output | 1 | Overrun interrupt request |
| irq_noise | output | 1 | Noise interrupt request |
| irq_frame | output | 1 | Framing-error interrupt request |

## Verification
The hardest situation to reach is an overrun that sets between the status read and the data read of a clearing sequence. The data read must then clear receive-full, noise and framing error but leave overrun set. The stimulus reaches it in three steps: a status read while receive-full is set, a second frame before the data read, then the data read itself. The same construction, with strobes placed in one cycle, reaches the set-versus-clear collision and the simultaneous status and data reads.

// File: rtl/uart_rx_status_pkg.sv
package uart_rx_status_pkg;
    localparam int NFLAG   = 4;
    localparam int F_FULL  = 0;
    localparam int F_OVR   = 1;
    localparam int F_NOISE = 2;
    localparam int F_FRAME = 3;

    localparam int SB_FULL  = 5;
    localparam int SB_OVR   = 3;
    localparam int SB_NOISE = 2;
    localparam int SB_FRAME = 1;

    typedef struct packed {
        logic flag;
        logic arm;
    } flag_state_t;

    function automatic logic [7:0] pack_status(input logic [NFLAG-1:0] f);
        logic [7:0] s;
        s           = 8'h00;
        s[SB_FULL]  = f[F_FULL];
        s[SB_OVR]   = f[F_OVR];
        s[SB_NOISE] = f[F_NOISE];
        s[SB_FRAME] = f[F_FRAME];
        return s;
    endfunction
endpackage

// File: rtl/uart_rx_flag_cell.sv
module uart_rx_flag_cell
    import uart_rx_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_stat_i,
    input  logic rd_data_i,
    output logic flag_o,
    output logic arm_o
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // the data read uses the arm captured earlier; a set in the same cycle wins
        st_d.flag = set_i | (st_q.flag & ~(rd_data_i & st_q.arm));
        if (rd_stat_i)
            st_d.arm = st_q.flag;
        else if (rd_data_i)
            st_d.arm = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign arm_o  = st_q.arm;

    AST_UNARMED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !st_q.arm) |=> st_q.flag); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> st_q.flag); // R10
    AST_ARM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_i && !rd_stat_i) |=> !st_q.arm); // R9
endmodule

// File: rtl/uart_rx_data_hold.sv
module uart_rx_data_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] byte_i,
    output logic [DW-1:0] data_o
);
    logic [DW-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (load_i) data_d = byte_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign data_o = data_q;

    AST_LOAD_TAKES_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (data_q == $past(byte_i))); // R2
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_status_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_done,
    input  logic [DW-1:0] frame_byte,
    input  logic          noise_in,
    input  logic          stop_bit_in,
    input  logic          rd_status,
    input  logic          rd_data,
    input  logic          en_overrun,
    input  logic          en_noise,
    input  logic          en_frame,
    output logic [7:0]    status,
    output logic [DW-1:0] rx_data,
    output logic          irq_overrun,
    output logic          irq_noise,
    output logic          irq_frame
);
    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] arm_q;
    logic [NFLAG-1:0] set_d;
    logic             accept_d;
    logic             full_clr_d;

    always_comb begin
        full_clr_d      = rd_data & arm_q[F_FULL];
        accept_d        = frame_done & (~flag_q[F_FULL] | full_clr_d);
        set_d           = '0;
        set_d[F_FULL]   = accept_d;
        set_d[F_OVR]    = frame_done & ~accept_d;
        set_d[F_NOISE]  = frame_done & noise_in;
        set_d[F_FRAME]  = frame_done & ~stop_bit_in;
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        uart_rx_flag_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (set_d[g]),
            .rd_stat_i (rd_status),
            .rd_data_i (rd_data),
            .flag_o    (flag_q[g]),
            .arm_o     (arm_q[g])
        );
    end

    uart_rx_data_hold #(.DW(DW)) u_data (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept_d),
        .byte_i (frame_byte),
        .data_o (rx_data)
    );

    assign status      = pack_status(flag_q);
    assign irq_overrun = flag_q[F_OVR]   & en_overrun;
    assign irq_noise   = flag_q[F_NOISE] & en_noise;
    assign irq_frame   = flag_q[F_FRAME] & en_frame;

    AST_OVR_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && status[SB_FULL] && !(rd_data && arm_q[F_FULL])) |=> $stable(rx_data)); // R1
    AST_OVR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && status[SB_FULL] && !(rd_data && arm_q[F_FULL])) |=> status[SB_OVR]); // R1
    AST_ACCEPT_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && rd_data && arm_q[F_FULL]) |=> (status[SB_FULL] && $past(frame_byte) == rx_data)); // R11
endmodule

// File: tb/sim_uart_rx_status.sv
module sim_uart_rx_status;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int NVEC = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_done = 1'b0;
    logic [DW-1:0] frame_byte = '0;
    logic          noise_in = 1'b0;
    logic          stop_bit_in = 1'b1;
    logic          rd_status = 1'b0;
    logic          rd_data = 1'b0;
    logic          en_overrun = 1'b1;
    logic          en_noise = 1'b1;
    logic          en_frame = 1'b1;
    logic [7:0]    status;
    logic [DW-1:0] rx_data;
    logic          irq_overrun, irq_noise, irq_frame;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_status #(.DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_byte(frame_byte),
        .noise_in(noise_in), .stop_bit_in(stop_bit_in), .rd_status(rd_status),
        .rd_data(rd_data), .en_overrun(en_overrun), .en_noise(en_noise),
        .en_frame(en_frame), .status(status), .rx_data(rx_data),
        .irq_overrun(irq_overrun), .irq_noise(irq_noise), .irq_frame(irq_frame)
    );

    // op: 1 frame, 2 status read, 3 data read | noise | stop | pad | byte | exp status | exp data
    localparam logic [31:0] VEC [NVEC] = '{
        {4'd1, 1'b0, 1'b1, 2'b0, 8'hA5, 8'h20, 8'hA5}, // R2 R8
        {4'd2, 1'b0, 1'b1, 2'b0, 8'h00, 8'h20, 8'hA5},
        {4'd3, 1'b0, 1'b1, 2'b0, 8'h00, 8'h00, 8'hA5}, // R3
        {4'd1, 1'b1, 1'b0, 2'b0, 8'h3C, 8'h26, 8'h3C}, // R4 R5
        {4'd2, 1'b0, 1'b1, 2'b0, 8'h00, 8'h26, 8'h3C},
        {4'd1, 1'b0, 1'b1, 2'b0, 8'h77, 8'h2E, 8'h3C}, // R1
        {4'd3, 1'b0, 1'b1, 2'b0, 8'h00, 8'h08, 8'h3C}, // R3 late overrun survives
        {4'd2, 1'b0, 1'b1, 2'b0, 8'h00, 8'h08, 8'h3C},
        {4'd3, 1'b0, 1'b1, 2'b0, 8'h00, 8'h00, 8'h3C},
        {4'd1, 1'b0, 1'b1, 2'b0, 8'h11, 8'h20, 8'h11},
        {4'd3, 1'b0, 1'b1, 2'b0, 8'h00, 8'h20, 8'h11}, // R9 unarmed read
        {4'd2, 1'b0, 1'b1, 2'b0, 8'h00, 8'h20, 8'h11},
        {4'd3, 1'b0, 1'b1, 2'b0, 8'h00, 8'h00, 8'h11}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        frame_done = 1'b0; rd_status = 1'b0; rd_data = 1'b0;
        noise_in = 1'b0; stop_bit_in = 1'b1;
    endtask

    // drive for one edge, then look after it
    task automatic step();
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        check("R7 status", status, 8'h00);
        check("R7 data", rx_data, 8'h00);
        check("R7 irq", {irq_overrun, irq_noise, irq_frame}, 3'b000);

        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] v;
            v = VEC[i];
            case (v[31:28])
                4'd1: begin frame_done = 1'b1; noise_in = v[27]; stop_bit_in = v[26]; frame_byte = v[23:16]; end
                4'd2: rd_status = 1'b1;
                default: rd_data = 1'b1;
            endcase
            step();
            check($sformatf("R1-table row %0d status (R3 R8)", i), status, v[15:8]);
            check($sformatf("R2 row %0d data", i), rx_data, v[7:0]);
            check($sformatf("R6 row %0d irq", i), {irq_overrun, irq_noise, irq_frame},
                  {status[3], status[2], status[1]});
        end

        // R6: enables off mask requests
        frame_done = 1'b1; noise_in = 1'b1; stop_bit_in = 1'b0; frame_byte = 8'h42; step();
        frame_done = 1'b1; frame_byte = 8'h43; step();
        check("R1 data kept", rx_data, 8'h42);
        check("R6 all on", {irq_overrun, irq_noise, irq_frame}, 3'b111);
        en_overrun = 1'b0; en_noise = 1'b0; en_frame = 1'b0; #1;
        check("R6 masked", {irq_overrun, irq_noise, irq_frame}, 3'b000);
        en_noise = 1'b1; #1;
        check("R6 noise only", {irq_overrun, irq_noise, irq_frame}, 3'b010);

        // R7: reset mid-run
        rst_n = 1'b0; step(); rst_n = 1'b1;
        check("R7 mid status", status, 8'h00);
        check("R7 mid data", rx_data, 8'h00);
        en_overrun = 1'b1; en_frame = 1'b1;

        // R10 R11: frame collides with armed data read of receive-full
        frame_done = 1'b1; frame_byte = 8'h55; step();
        rd_status = 1'b1; step();
        rd_data = 1'b1; frame_done = 1'b1; frame_byte = 8'h66; step();
        check("R10 full stays", status, 8'h20);
        check("R11 byte accepted", rx_data, 8'h66);

        // R12: simultaneous reads use old (dropped) arms, then rearm
        rd_status = 1'b1; rd_data = 1'b1; step();
        check("R12 no clear on concurrent", status, 8'h20);
        rd_data = 1'b1; step();
        check("R12 rearmed clear", status, 8'h00);

        // R10: noise set collides with its armed clear
        frame_done = 1'b1; noise_in = 1'b1; frame_byte = 8'h01; step();
        rd_status = 1'b1; step();
        rd_data = 1'b1; frame_done = 1'b1; noise_in = 1'b1; frame_byte = 8'h02; step();
        check("R10 noise stays", status, 8'h24);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule